// File: doc/BRIEF.md
# Network Controller Command and Status Register

This block is the host-facing control register pair of a small network controller. A 16-bit status word collects event flags from the controller's internal engines. It also shows the current state of the receive engine and of the command engine. A 16-bit command word carries one opcode for each engine, an interrupt-disable bit and a software-interrupt trigger. The host clears event flags by writing ones to them. It issues work by writing an opcode, then polls the command word until that opcode field reads back as zero.

Each opcode field acts as a one-deep request slot. A legal opcode written to an empty slot raises a request towards its engine. When the engine accepts it, the slot empties and the field reads back as zero. A write that would replace an opcode still waiting in its slot is refused in full, and a sticky error bit records the refusal. A level interrupt output follows the event flags unless the host has disabled it. In this block the engines are stand-ins: accept strobes, event pulses and state inputs.

Top module: `nic_scb_regs`

## Requirements
- R1: After a synchronous active-high reset, both words read zero, `irq` is low, and both request outputs are low. A zero state field means idle.
- R2: Each event input sets its status bit on the following clock edge. The mapping is command done to bit 15, frame received to bit 14, command engine left active to bit 13, receiver left ready to bit 12, management cycle done to bit 11, and flow-control pause to bit 8.
- R3: A status write clears every event bit (mask 0xFD00) that is written as 1 and leaves the bits written as 0 unchanged. An event that arrives in the same cycle as the clear wins, and its bit stays set.
- R4: The command-engine opcode sits in command bits 7:4. Only codes 1, 2, 4, 5, 6 and 7 are legal. A legal code written to an empty slot shows in bits 7:4 and on `cu_op`, with `cu_req` high. Codes 0, 3 and 8 to 15 are treated as no operation and leave the slot empty.
- R5: The receive-engine opcode sits in command bits 2:0. Only codes 1, 2, 4, 6 and 7 are legal. Codes 0, 3 and 5 are treated as no operation.
- R6: When an engine accepts while its request is high, the opcode field reads zero and the request drops after the next edge.
- R7: Command bit 8 is stored and reads back. Writing 1 to command bit 9 sets status bit 10 (software interrupt), and bit 9 reads back as 0.
- R8: `irq` is high exactly when any event bit in mask 0xFD00 is set and command bit 8 is 0.
- R9: A command write that carries a legal opcode for an engine whose slot is still occupied is ignored entirely, including its bits 8 and 9. Such a write sets status bit 9, which stays set until reset, and status writes do not clear it.
- R10: A command write in the same cycle as the accept of that engine's pending opcode is taken. The new opcode replaces the accepted one.
- R11: Status bits 7:6 show `cu_state_in` and bits 5:2 show `ru_state_in`, one cycle later. In the receive encoding, 0 is idle, 1 is suspended, 2 is no resources and 4 is ready, and bit 5 flags that no buffer descriptors are left. Status bits 1:0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_wr | input | 1 | Host write strobe for the status word |
| stat_wdata | input | 16 | Write-one-to-clear data for the status word |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 16 | Command word write data |
| status_q | output | 16 | Status word read value |
| command_q | output | 16 | Command word read value |
| cu_req | output | 1 | Command-engine opcode waiting |
| cu_op | output | 4 | Pending command-engine opcode |
| cu_accept | input | 1 | Command engine takes the pending opcode |
| ru_req | output | 1 | Receive-engine opcode waiting |
| ru_op | output | 3 | Pending receive-engine opcode |
| ru_accept | input | 1 | Receive engine takes the pending opcode |
| ev_cmd_done | input | 1 | Event: command finished |
| ev_frame_rx | input | 1 | Event: frame received |
| ev_cu_left | input | 1 | Event: command engine left active state |
| ev_ru_left | input | 1 | Event: receiver left ready state |
| ev_mgmt_done | input | 1 | Event: management cycle done |
| ev_fc_pause | input | 1 | Event: flow-control pause |
| cu_state_in | input | 2 | Command-engine state to report |
| ru_state_in | input | 4 | Receive-engine state to report |
| irq | output | 1 | Level interrupt |

## Verification
Every receive code from 0 to 7 is written in turn, and a legal and an illegal command code are written as well. Together these separate the legal-code tables from the no-operation handling and show that nothing latches a code that must be dropped. Back-to-back writes to a busy slot are set against a write that lands in the very cycle of its accept. This tells a correct refusal apart from a slot that frees one cycle too late. Single event pulses, clears with ones and zeros, and a clear that collides with a new event check the bit mapping and the set-over-clear priority. Toggling the interrupt-disable bit and the software trigger shows the interrupt path apart from the flags themselves.

// File: rtl/nic_scb_pkg.sv
package nic_scb_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CU_OP_W  = 4;
  localparam int unsigned RU_OP_W  = 3;
  localparam int unsigned CU_ST_W  = 2;
  localparam int unsigned RU_ST_W  = 4;

  // event flags that write-one-to-clear acts on
  localparam logic [WORD_W-1:0] EVT_MASK = 16'hFD00;

  // legal opcode tables: bit n set means code n is a real command
  localparam logic [(1<<CU_OP_W)-1:0] CU_LEGAL = 16'h00F6;
  localparam logic [(1<<RU_OP_W)-1:0] RU_LEGAL = 8'hD6;

  // field positions inside the command word
  localparam int unsigned CMD_RU_LSB = 0;
  localparam int unsigned CMD_CU_LSB = 4;
  localparam int unsigned CMD_MASK_B = 8;
  localparam int unsigned CMD_SWI_B  = 9;
  localparam int unsigned STAT_ERR_B = 9;

  // next value of the event register: clears first, new events win
  function automatic logic [WORD_W-1:0] evt_next(
      input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] set_v,
      input logic [WORD_W-1:0] clr_v);
    return ((cur & ~clr_v) | set_v) & EVT_MASK;
  endfunction

  function automatic logic irq_level(
      input logic [WORD_W-1:0] evt,
      input logic              disable_b);
    return (|(evt & EVT_MASK)) & ~disable_b;
  endfunction
endpackage

// File: rtl/scb_cmd_slot.sv
module scb_cmd_slot #(
  parameter int unsigned OP_W = 4,
  parameter logic [(1<<OP_W)-1:0] LEGAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] field,
  input  logic            take,
  input  logic            accept,
  output logic            legal,
  output logic            busy,
  output logic            pending,
  output logic [OP_W-1:0] op_q
);
  logic load;

  assign legal   = LEGAL[field];
  assign pending = (op_q != '0);
  // a slot being accepted this cycle counts as free
  assign busy    = pending & ~accept;
  assign load    = take & legal;

  always_ff @(posedge clk) begin
    if (rst)                    op_q <= '0;
    else if (load)              op_q <= field;
    else if (accept && pending) op_q <= '0;
  end
endmodule

// File: rtl/scb_event_reg.sv
module scb_event_reg
  import nic_scb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_v,
  input  logic              clr_wr,
  input  logic [WORD_W-1:0] clr_data,
  output logic [WORD_W-1:0] evt_q
);
  logic [WORD_W-1:0] clr_v;
  assign clr_v = clr_wr ? (clr_data & EVT_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_next(evt_q, set_v, clr_v);
  end
endmodule

// File: rtl/nic_scb_regs.sv
module nic_scb_regs
  import nic_scb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stat_wr,
  input  logic [WORD_W-1:0]  stat_wdata,
  input  logic               cmd_wr,
  input  logic [WORD_W-1:0]  cmd_wdata,
  output logic [WORD_W-1:0]  status_q,
  output logic [WORD_W-1:0]  command_q,
  output logic               cu_req,
  output logic [CU_OP_W-1:0] cu_op,
  input  logic               cu_accept,
  output logic               ru_req,
  output logic [RU_OP_W-1:0] ru_op,
  input  logic               ru_accept,
  input  logic               ev_cmd_done,
  input  logic               ev_frame_rx,
  input  logic               ev_cu_left,
  input  logic               ev_ru_left,
  input  logic               ev_mgmt_done,
  input  logic               ev_fc_pause,
  input  logic [CU_ST_W-1:0] cu_state_in,
  input  logic [RU_ST_W-1:0] ru_state_in,
  output logic               irq
);
  logic [CU_OP_W-1:0] cu_field;
  logic [RU_OP_W-1:0] ru_field;
  logic cu_legal, cu_busy, ru_legal, ru_busy;
  logic cmd_collide, cmd_take, swi_set;
  logic irq_dis_q, err_q;
  logic [CU_ST_W-1:0] cu_st_q;
  logic [RU_ST_W-1:0] ru_st_q;
  logic [WORD_W-1:0]  evt_set, evt_q;
  logic unused_cmd_bits;

  assign cu_field = cmd_wdata[CMD_CU_LSB +: CU_OP_W];
  assign ru_field = cmd_wdata[CMD_RU_LSB +: RU_OP_W];
  assign unused_cmd_bits = ^{cmd_wdata[WORD_W-1:10], cmd_wdata[3]};

  // refusal: a real opcode aimed at a slot that is still occupied
  assign cmd_collide = cmd_wr & ((cu_legal & cu_busy) | (ru_legal & ru_busy));
  assign cmd_take    = cmd_wr & ~cmd_collide;
  assign swi_set     = cmd_take & cmd_wdata[CMD_SWI_B];

  scb_cmd_slot #(.OP_W(CU_OP_W), .LEGAL(CU_LEGAL)) cu_slot_i (
    .clk(clk), .rst(rst), .field(cu_field), .take(cmd_take),
    .accept(cu_accept), .legal(cu_legal), .busy(cu_busy),
    .pending(cu_req), .op_q(cu_op));

  scb_cmd_slot #(.OP_W(RU_OP_W), .LEGAL(RU_LEGAL)) ru_slot_i (
    .clk(clk), .rst(rst), .field(ru_field), .take(cmd_take),
    .accept(ru_accept), .legal(ru_legal), .busy(ru_busy),
    .pending(ru_req), .op_q(ru_op));

  assign evt_set = {ev_cmd_done, ev_frame_rx, ev_cu_left, ev_ru_left,
                    ev_mgmt_done, swi_set, 1'b0, ev_fc_pause, 8'h00};

  scb_event_reg evt_i (
    .clk(clk), .rst(rst), .set_v(evt_set), .clr_wr(stat_wr),
    .clr_data(stat_wdata), .evt_q(evt_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_dis_q <= 1'b0;
      err_q     <= 1'b0;
      cu_st_q   <= '0;
      ru_st_q   <= '0;
    end else begin
      if (cmd_take)    irq_dis_q <= cmd_wdata[CMD_MASK_B];
      if (cmd_collide) err_q     <= 1'b1;
      cu_st_q <= cu_state_in;
      ru_st_q <= ru_state_in;
    end
  end

  always_comb begin
    status_q = evt_q;
    status_q[STAT_ERR_B] = err_q;
    status_q[7:6] = cu_st_q;
    status_q[5:2] = ru_st_q;
    status_q[1:0] = 2'b00;
  end

  always_comb begin
    command_q = '0;
    command_q[CMD_CU_LSB +: CU_OP_W] = cu_op;
    command_q[CMD_RU_LSB +: RU_OP_W] = ru_op;
    command_q[CMD_MASK_B] = irq_dis_q;
  end

  assign irq = irq_level(evt_q, irq_dis_q);
endmodule

// File: rtl/nic_scb_chk.sv
module nic_scb_chk (
  input logic        clk,
  input logic        rst,
  input logic        stat_wr,
  input logic [15:0] stat_wdata,
  input logic [15:0] status_q,
  input logic [15:0] command_q,
  input logic        cu_req,
  input logic        cu_accept,
  input logic        ev_cmd_done,
  input logic        ev_frame_rx,
  input logic        irq,
  input logic        cmd_collide,
  input logic        cmd_take,
  input logic        cu_legal
);
  AST_FRAME_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_frame_rx |=> status_q[14]);                                   // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_wdata[15] && !ev_cmd_done) |=> !status_q[15]);  // R3
  AST_ACCEPT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (cu_req && cu_accept && !(cmd_take && cu_legal)) |=> (command_q[7:4] == 4'h0 && !cu_req)); // R6
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
    command_q[8] |-> !irq);                                           // R8
  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    cmd_collide |=> status_q[9]);                                     // R9
  AST_REFUSE_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
    cmd_collide |=> $stable(command_q[8]));                           // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    status_q[9] |=> status_q[9]);                                     // R9
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_q[1:0] == 2'b00);                                          // R11
endmodule

bind nic_scb_regs nic_scb_chk chk_i (
  .clk(clk), .rst(rst), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
  .status_q(status_q), .command_q(command_q), .cu_req(cu_req),
  .cu_accept(cu_accept), .ev_cmd_done(ev_cmd_done),
  .ev_frame_rx(ev_frame_rx), .irq(irq), .cmd_collide(cmd_collide),
  .cmd_take(cmd_take), .cu_legal(cu_legal));

// File: tb/nic_scb_regs_tb.sv
module nic_scb_regs_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic stat_wr, cmd_wr, cu_accept, ru_accept;
  logic [15:0] stat_wdata, cmd_wdata, status_q, command_q;
  logic cu_req, ru_req, irq;
  logic [3:0] cu_op;
  logic [2:0] ru_op;
  logic ev_cmd_done, ev_frame_rx, ev_cu_left, ev_ru_left, ev_mgmt_done, ev_fc_pause;
  logic [1:0] cu_state_in;
  logic [3:0] ru_state_in;
  int n_checks = 0;
  int n_errs = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nic_scb_regs dut_i (
    .clk(clk), .rst(rst), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .status_q(status_q),
    .command_q(command_q), .cu_req(cu_req), .cu_op(cu_op),
    .cu_accept(cu_accept), .ru_req(ru_req), .ru_op(ru_op),
    .ru_accept(ru_accept), .ev_cmd_done(ev_cmd_done),
    .ev_frame_rx(ev_frame_rx), .ev_cu_left(ev_cu_left),
    .ev_ru_left(ev_ru_left), .ev_mgmt_done(ev_mgmt_done),
    .ev_fc_pause(ev_fc_pause), .cu_state_in(cu_state_in),
    .ru_state_in(ru_state_in), .irq(irq));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    stat_wr = 0; cmd_wr = 0; stat_wdata = '0; cmd_wdata = '0;
    cu_accept = 0; ru_accept = 0;
    ev_cmd_done = 0; ev_frame_rx = 0; ev_cu_left = 0; ev_ru_left = 0;
    ev_mgmt_done = 0; ev_fc_pause = 0;
  endtask

  // one host write, result visible at the following negedge
  task automatic write_cmd(input logic [15:0] d);
    cmd_wr = 1; cmd_wdata = d;
    @(negedge clk);
    cmd_wr = 0; cmd_wdata = '0;
  endtask

  task automatic write_stat(input logic [15:0] d);
    stat_wr = 1; stat_wdata = d;
    @(negedge clk);
    stat_wr = 0; stat_wdata = '0;
  endtask

  task automatic accept_both();
    cu_accept = 1; ru_accept = 1;
    @(negedge clk);
    cu_accept = 0; ru_accept = 0;
  endtask

  task automatic t_reset();
    check("R1 status", status_q, 16'h0000);
    check("R1 command", command_q, 16'h0000);
    check("R1 irq/req", {13'b0, irq, cu_req, ru_req}, 16'h0000);
  endtask

  task automatic t_events();
    ev_frame_rx = 1; @(negedge clk); ev_frame_rx = 0;
    check("R2 frame bit14", status_q, 16'h4000);
    check("R8 irq on event", {15'b0, irq}, 16'h1);
    ev_cmd_done = 1; ev_cu_left = 1; ev_ru_left = 1; ev_mgmt_done = 1; ev_fc_pause = 1;
    @(negedge clk); idle_inputs();
    check("R2 all events", status_q, 16'hF900);
    write_stat(16'h0000);
    check("R3 write zero keeps", status_q, 16'hF900);
    write_stat(16'h8100);
    check("R3 clear 15 and 8", status_q, 16'h7800);
    ev_frame_rx = 1; stat_wr = 1; stat_wdata = 16'h4000;
    @(negedge clk); idle_inputs();
    check("R3 set beats clear", status_q, 16'h7800);
    write_stat(16'hFFFF);
    check("R3 clear all", status_q, 16'h0000);
    check("R8 irq low no events", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_cu_ops();
    write_cmd(16'h0010);
    check("R4 cu start field", command_q, 16'h0010);
    check("R4 cu req/op", {11'b0, cu_req, cu_op}, {11'b0, 1'b1, 4'h1});
    accept_both();
    check("R6 cu accepted", {command_q[15:1], cu_req}, 16'h0000);
    write_cmd(16'h0030);
    check("R4 cu code 3 nop", {command_q[15:1], cu_req}, 16'h0000);
    write_cmd(16'h00F0);
    check("R4 cu code 15 nop", {command_q[15:1], cu_req}, 16'h0000);
    check("R4 nop no error", {15'b0, status_q[9]}, 16'h0);
  endtask

  task automatic t_ru_ops();
    for (int c = 0; c < 8; c++) begin
      logic lg;
      lg = (c == 1) || (c == 2) || (c == 4) || (c == 6) || (c == 7);
      write_cmd(16'(c));
      check($sformatf("R5 ru code %0d", c), {12'b0, ru_req, ru_op},
            lg ? {12'b0, 1'b1, 3'(c)} : 16'h0000);
      accept_both();
      check($sformatf("R6 ru empty after %0d", c), command_q, 16'h0000);
    end
  endtask

  task automatic t_collide();
    write_cmd(16'h0040);
    write_cmd(16'h0320);
    check("R9 refused write", command_q, 16'h0040);
    check("R9 err flag", {15'b0, status_q[9]}, 16'h1);
    check("R9 no swi from refused", {15'b0, status_q[10]}, 16'h0);
    write_stat(16'hFFFF);
    check("R9 err survives w1c", {15'b0, status_q[9]}, 16'h1);
    cu_accept = 1; cmd_wr = 1; cmd_wdata = 16'h0050;
    @(negedge clk); idle_inputs();
    check("R10 write in accept cycle", command_q, 16'h0050);
    accept_both();
    check("R6 empty", command_q, 16'h0000);
  endtask

  task automatic t_mask_swi();
    write_cmd(16'h0200);
    check("R7 swi sets bit10", status_q & 16'hFD00, 16'h0400);
    check("R7 swi reads 0", command_q, 16'h0000);
    check("R8 irq from swi", {15'b0, irq}, 16'h1);
    write_cmd(16'h0100);
    check("R7 mask readback", command_q, 16'h0100);
    check("R8 irq masked", {15'b0, irq}, 16'h0);
    write_cmd(16'h0000);
    check("R8 irq unmasked", {15'b0, irq}, 16'h1);
  endtask

  task automatic t_state();
    cu_state_in = 2'd2; ru_state_in = 4'd4;
    @(negedge clk);
    check("R11 states", {8'b0, status_q[7:0]}, 16'h0090);
    ru_state_in = 4'b1010;
    @(negedge clk);
    check("R11 no-rbd nores", {12'b0, status_q[5:2]}, 16'h000A);
    check("R11 low bits", {14'b0, status_q[1:0]}, 16'h0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    cu_state_in = '0; ru_state_in = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_events();
    t_cu_ops();
    t_ru_ops();
    t_collide();
    t_mask_swi();
    t_state();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule